// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter and Receiver

This block is a full-duplex asynchronous serial core. Static configuration inputs fix the character format: five to eight data bits from a two-bit width code, parity on or off, even or odd parity, and one or two transmitted stop bits. A shared enable pulses at sixteen times the bit rate. Both the transmitter and the receiver count these pulses to time every bit. The divider that makes this enable sits outside the block, and so does the register decoding around the core.

The host side hands a character to the transmitter with a one-cycle load while the transmitter reports that it is ready. The transmitter then sends a start bit, the data least-significant bit first, an optional parity bit and the stop bits. A break input forces the line to the space level while it is held. The receiver watches the serial input, confirms a start bit in the middle of the bit and samples each later bit at its centre. It then presents the character right-justified, with the received parity bit in bit 7 when the character is narrower than eight bits. It flags a bad stop bit as a framing error and can turn that error into a halt request for the processor. A one-cycle strobe marks each confirmed start bit, so that an outer register layer can clear its reader-advance control.

Top module: `async_serial_core`

## Requirements
- R1: `widthCode[1:0]` selects the data width, where a 1 means the selector is fitted. Bit 0 is the first selector and bit 1 is the second. 2'b11 gives 5 bits, 2'b10 gives 6, 2'b01 gives 7 and 2'b00 gives 8. The transmitter and the receiver both use this width.
- R2: The transmit line idles at mark (1). A frame is one start bit (0), the data bits least-significant first, the parity bit when `parityOn` is 1, and then one stop bit (1), or two when `twoStop` is 1. Every bit lasts 16 `tickEn` pulses.
- R3: When `parityOn` is 1 and `parityOdd` is 0, the parity bit makes the count of ones over data and parity even. When `parityOdd` is 1, that count is odd.
- R4: `txReady` is 1 while the transmitter is idle. It falls on the clock edge that accepts `txLoad`. A `txLoad` while `txReady` is 0 is ignored: the frame in progress is unchanged and no further frame follows it.
- R5: While `txBreak` is 1, `txLine` is 0 from the next clock edge on, whether a frame is in progress or not.
- R6: The receiver starts a character only if the line is still low eight sample ticks after the first low sample. A low pulse shorter than half a bit produces neither `startSeen` nor `rxValid`.
- R7: `startSeen` is a one-cycle pulse for each confirmed start bit.
- R8: `rxData` holds the received data right-justified, and unused upper bits read 0. When the width is under 8 and `parityOn` is 1, bit 7 carries the received parity bit as it arrived, without any check. With 8-bit data no parity bit is reported.
- R9: `rxValid` pulses for one cycle when the stop position has been sampled. `frameErr` is 1 if that sample was 0 and holds until the next character completes. After a bad stop bit, the receiver waits for mark before it looks for a new start.
- R10: `haltReq` pulses together with `rxValid` when the character had a framing error and `haltOnFrameErr` is 1. It stays 0 when `haltOnFrameErr` is 0.
- R11: After reset, `txLine` is 1, `txReady` is 1, and `rxValid`, `frameErr`, `haltReq` and `startSeen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tickEn | input | 1 | Enable at 16x the bit rate |
| widthCode | input | 2 | Data width selection code |
| parityOn | input | 1 | Append and expect a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| twoStop | input | 1 | Transmit two stop bits |
| haltOnFrameErr | input | 1 | Turn framing errors into halt requests |
| txLoad | input | 1 | Load strobe for a transmit character |
| txData | input | 8 | Transmit character, right-justified |
| txBreak | input | 1 | Hold the transmit line at space |
| txReady | output | 1 | Transmitter idle and able to take a load |
| txLine | output | 1 | Serial transmit line |
| rxLine | input | 1 | Serial receive line |
| rxData | output | 8 | Received character and parity bit |
| rxValid | output | 1 | Received character complete |
| frameErr | output | 1 | Last character had a bad stop bit |
| haltReq | output | 1 | Halt request pulse |
| startSeen | output | 1 | Start bit confirmed pulse |

## Verification
The transmit shifter and the receive sampler run off the same `tickEn` pulses, so a transmit bit boundary and a receive sample can land in the same cycle. The bench provokes this by loading a transmit character and starting a receive frame on the same clock, so that both sides run their bit counters in lockstep through a whole character. Each side is then judged against its own expected value: the captured transmit frame bit by bit, and the received data with its error flag, exactly as in the isolated tests.

// File: rtl/async_serial_pkg.sv
package async_serial_pkg;
  localparam int DATA_MAX  = 8;
  localparam int FRAME_MAX = DATA_MAX + 4;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic             txLoad;
    logic             txShift;
    logic             rxClear;
    logic             rxSample;
    logic             rxLast;
    logic [LEN_W-1:0] rxIdx;
  } strobe_t;

  function automatic logic [LEN_W-1:0] widthFromCode(input logic [1:0] code);
    return LEN_W'(DATA_MAX) - LEN_W'(code);
  endfunction
endpackage

// File: rtl/async_serial_ctrl.sv
module async_serial_ctrl
  import async_serial_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             txLoadReq,
  input  logic             rxIn,
  input  logic [LEN_W-1:0] dataBits,
  input  logic             parityOn,
  input  logic             twoStop,
  output strobe_t          st,
  output logic             txReady,
  output logic             startSeen
);
  localparam int TICK_W = $clog2(OVERSAMPLE);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVERSAMPLE - 1);
  localparam logic [TICK_W-1:0] TICK_HALF = TICK_W'(OVERSAMPLE / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_FRAME, RX_WAIT_MARK} rxState_t;

  logic              txBusy;
  logic [TICK_W-1:0] txTick;
  logic [LEN_W-1:0]  txLeft;
  logic [LEN_W-1:0]  txLen;
  logic [LEN_W-1:0]  rxLen;

  rxState_t          rxState;
  logic [TICK_W-1:0] rxTick;
  logic [LEN_W-1:0]  rxIdx;

  always_comb begin
    txLen = dataBits + LEN_W'(parityOn) + (twoStop ? LEN_W'(3) : LEN_W'(2));
    rxLen = dataBits + LEN_W'(parityOn) + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txBusy <= 1'b0;
      txTick <= '0;
      txLeft <= '0;
    end else if (!txBusy) begin
      if (txLoadReq) begin
        txBusy <= 1'b1;
        txLeft <= txLen;
        txTick <= '0;
      end
    end else if (tickEn) begin
      if (txTick == TICK_LAST) begin
        txTick <= '0;
        txLeft <= txLeft - LEN_W'(1);
        if (txLeft == LEN_W'(1)) txBusy <= 1'b0;
      end else begin
        txTick <= txTick + TICK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxIdx   <= '0;
    end else if (tickEn) begin
      unique case (rxState)
        RX_IDLE: begin
          if (!rxIn) begin
            rxState <= RX_START;
            rxTick  <= '0;
          end
        end
        RX_START: begin
          if (rxTick == TICK_HALF) begin
            rxTick  <= '0;
            rxIdx   <= '0;
            rxState <= rxIn ? RX_IDLE : RX_FRAME;
          end else begin
            rxTick <= rxTick + TICK_W'(1);
          end
        end
        RX_FRAME: begin
          if (rxTick == TICK_LAST) begin
            rxTick <= '0;
            rxIdx  <= rxIdx + LEN_W'(1);
            if (rxIdx == rxLen - LEN_W'(1))
              rxState <= rxIn ? RX_IDLE : RX_WAIT_MARK;
          end else begin
            rxTick <= rxTick + TICK_W'(1);
          end
        end
        RX_WAIT_MARK: begin
          if (rxIn) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    st.txLoad   = !txBusy && txLoadReq;
    st.txShift  = txBusy && tickEn && (txTick == TICK_LAST);
    st.rxClear  = (rxState == RX_START) && tickEn && (rxTick == TICK_HALF) && !rxIn;
    st.rxSample = (rxState == RX_FRAME) && tickEn && (rxTick == TICK_LAST);
    st.rxLast   = st.rxSample && (rxIdx == rxLen - LEN_W'(1));
    st.rxIdx    = rxIdx;
    txReady     = !txBusy;
    startSeen   = st.rxClear;
  end
endmodule

// File: rtl/async_serial_dp.sv
module async_serial_dp
  import async_serial_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             st,
  input  logic                txReady,
  input  logic [DATA_MAX-1:0] txData,
  input  logic                txBreak,
  input  logic [LEN_W-1:0]    dataBits,
  input  logic                parityOn,
  input  logic                parityOdd,
  input  logic                haltOnFrameErr,
  input  logic                rxLine,
  output logic                rxIn,
  output logic                txLine,
  output logic [DATA_MAX-1:0] rxData,
  output logic                rxValid,
  output logic                frameErr,
  output logic                haltReq
);
  logic                 rxSync1;
  logic [FRAME_MAX-1:0] txShreg;
  logic [FRAME_MAX-1:0] txFrame;
  logic                 txParity;
  logic                 bitOut;
  logic [DATA_MAX:0]    rxBuf;
  logic [DATA_MAX-1:0]  rxAssembled;

  always_comb begin
    txParity = parityOdd;
    for (int i = 0; i < DATA_MAX; i++)
      if (LEN_W'(i) < dataBits) txParity = txParity ^ txData[i];
    txFrame    = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++)
      if (LEN_W'(i) < dataBits) txFrame[i+1] = txData[i];
    for (int i = DATA_MAX - 3; i <= DATA_MAX; i++)
      if (parityOn && LEN_W'(i) == dataBits) txFrame[i+1] = txParity;
  end

  always_comb bitOut = txReady ? 1'b1 : txShreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txShreg <= '1;
      txLine  <= 1'b1;
    end else begin
      if (st.txLoad)       txShreg <= txFrame;
      else if (st.txShift) txShreg <= {1'b1, txShreg[FRAME_MAX-1:1]};
      txLine <= txBreak ? 1'b0 : bitOut;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxSync1 <= 1'b1;
      rxIn    <= 1'b1;
    end else begin
      rxSync1 <= rxLine;
      rxIn    <= rxSync1;
    end
  end

  always_comb begin
    rxAssembled = '0;
    for (int i = 0; i < DATA_MAX; i++)
      if (LEN_W'(i) < dataBits) rxAssembled[i] = rxBuf[i];
    if (parityOn && dataBits < LEN_W'(DATA_MAX))
      rxAssembled[DATA_MAX-1] = rxBuf[dataBits];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxBuf    <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      frameErr <= 1'b0;
      haltReq  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      haltReq <= 1'b0;
      if (st.rxClear) rxBuf <= '0;
      if (st.rxSample && !st.rxLast) begin
        for (int i = 0; i <= DATA_MAX; i++)
          if (st.rxIdx == LEN_W'(i)) rxBuf[i] <= rxIn;
      end
      if (st.rxLast) begin
        rxData   <= rxAssembled;
        rxValid  <= 1'b1;
        frameErr <= !rxIn;
        haltReq  <= !rxIn && haltOnFrameErr;
      end
    end
  end
endmodule

// File: rtl/async_serial_core.sv
module async_serial_core
  import async_serial_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  logic [1:0] widthCode,
  input  logic       parityOn,
  input  logic       parityOdd,
  input  logic       twoStop,
  input  logic       haltOnFrameErr,
  input  logic       txLoad,
  input  logic [7:0] txData,
  input  logic       txBreak,
  output logic       txReady,
  output logic       txLine,
  input  logic       rxLine,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       frameErr,
  output logic       haltReq,
  output logic       startSeen
);
  strobe_t          st;
  logic             rxIn;
  logic [LEN_W-1:0] dataBits;

  always_comb dataBits = widthFromCode(widthCode);

  async_serial_ctrl #(.OVERSAMPLE(OVERSAMPLE)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .txLoadReq(txLoad),
    .rxIn(rxIn), .dataBits(dataBits), .parityOn(parityOn), .twoStop(twoStop),
    .st(st), .txReady(txReady), .startSeen(startSeen)
  );

  async_serial_dp i_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .txReady(txReady), .txData(txData),
    .txBreak(txBreak), .dataBits(dataBits), .parityOn(parityOn),
    .parityOdd(parityOdd), .haltOnFrameErr(haltOnFrameErr), .rxLine(rxLine),
    .rxIn(rxIn), .txLine(txLine), .rxData(rxData), .rxValid(rxValid),
    .frameErr(frameErr), .haltReq(haltReq)
  );
endmodule

// File: rtl/async_serial_checker.sv
module async_serial_checker (
  input logic clk,
  input logic rst_n,
  input logic txLoad,
  input logic txBreak,
  input logic txReady,
  input logic txLine,
  input logic rxValid,
  input logic frameErr,
  input logic haltReq,
  input logic haltOnFrameErr,
  input logic startSeen
);
  AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(txBreak) |-> !txLine); // R5
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(txReady) && !$past(txBreak)) |-> txLine); // R2
  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (txLoad && txReady) |=> !txReady); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid); // R9
  AST_HALT_ON_FE: assert property (@(posedge clk) disable iff (!rst_n)
    haltReq |-> (rxValid && frameErr && haltOnFrameErr)); // R10
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    startSeen |=> !startSeen); // R7
endmodule

bind async_serial_core async_serial_checker i_checker (
  .clk(clk), .rst_n(rst_n), .txLoad(txLoad), .txBreak(txBreak),
  .txReady(txReady), .txLine(txLine), .rxValid(rxValid), .frameErr(frameErr),
  .haltReq(haltReq), .haltOnFrameErr(haltOnFrameErr), .startSeen(startSeen)
);

// File: tb/test_async_serial_core.sv
module test_async_serial_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b1;
  logic [1:0] widthCode = 2'b00;
  logic       parityOn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0, haltOnFrameErr = 1'b0;
  logic       txLoad = 1'b0, txBreak = 1'b0, rxLine = 1'b1;
  logic [7:0] txData = '0;
  logic       txReady, txLine, rxValid, frameErr, haltReq, startSeen;
  logic [7:0] rxData;

  int checks = 0, errors = 0;
  int validCnt = 0, startCnt = 0, haltCnt = 0;
  logic [7:0] lastData;
  logic lastFe, lastHalt;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_serial_core i_async_serial_core (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .widthCode(widthCode),
    .parityOn(parityOn), .parityOdd(parityOdd), .twoStop(twoStop),
    .haltOnFrameErr(haltOnFrameErr), .txLoad(txLoad), .txData(txData),
    .txBreak(txBreak), .txReady(txReady), .txLine(txLine), .rxLine(rxLine),
    .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr),
    .haltReq(haltReq), .startSeen(startSeen)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      validCnt++;
      lastData = rxData;
      lastFe   = frameErr;
      lastHalt = haltReq;
    end
    if (startSeen) startCnt++;
    if (haltReq) haltCnt++;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic parOf(input logic [7:0] d, input int nd, input logic odd);
    logic p = odd;
    for (int i = 0; i < nd; i++) p = p ^ d[i];
    return p;
  endfunction

  // frame bits in line order, bit 0 first (start); stops fill with ones
  function automatic logic [11:0] mkFrame(input logic [7:0] d, input int nd,
                                          input logic pOn, input logic odd);
    logic [11:0] f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) f[1+i] = d[i];
    if (pOn) f[1+nd] = parOf(d, nd, odd);
    return f;
  endfunction

  task automatic setCfg(input int nd, input logic pOn, input logic odd, input logic two);
    widthCode = 2'(8 - nd);
    parityOn  = pOn;
    parityOdd = odd;
    twoStop   = two;
  endtask

  task automatic txCapture(input int len, output logic [11:0] got);
    int waitCnt = 0;
    got = '0;
    while (txLine !== 1'b0 && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    repeat (8) @(negedge clk);
    got[0] = txLine;
    for (int k = 1; k < len; k++) begin
      repeat (16) @(negedge clk);
      got[k] = txLine;
    end
  endtask

  task automatic txPulse(input logic [7:0] d);
    txData = d;
    txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0;
  endtask

  task automatic rxDrive(input logic [11:0] f, input int len);
    for (int k = 0; k < len; k++) begin
      rxLine = f[k];
      repeat (16) @(negedge clk);
    end
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] expRx(input logic [11:0] f, input int nd, input logic pOn);
    logic [7:0] r = '0;
    for (int i = 0; i < nd; i++) r[i] = f[1+i];
    if (pOn && nd < 8) r[7] = f[1+nd];
    return r;
  endfunction

  task automatic testReset();
    chk("R11 txLine", txLine, 1);
    chk("R11 txReady", txReady, 1);
    chk("R11 rxValid", rxValid, 0);
    chk("R11 frameErr", frameErr, 0);
    chk("R11 haltReq", haltReq, 0);
    chk("R11 startSeen", startSeen, 0);
  endtask

  task automatic testTx(input string req, input logic [7:0] d, input int nd,
                        input logic pOn, input logic odd, input logic two);
    int len = 1 + nd + int'(pOn) + (two ? 2 : 1);
    logic [11:0] got, exp, mask;
    setCfg(nd, pOn, odd, two);
    @(negedge clk);
    txPulse(d);
    chk({req, " R4 ready low after load"}, txReady, 0);
    txCapture(len, got);
    mask = 12'((1 << len) - 1);
    exp  = mkFrame(d, nd, pOn, odd) & mask;
    chk({req, " frame"}, got & mask, exp);
    repeat (12) @(negedge clk);
    chk({req, " R4 ready after frame"}, txReady, 1);
    chk({req, " R2 idle mark"}, txLine, 1);
  endtask

  task automatic testLoadBusy();
    logic [11:0] got;
    logic stayedMark = 1'b1;
    setCfg(8, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    txPulse(8'h3C);
    fork
      txCapture(10, got);
      begin
        repeat (20) @(negedge clk);
        txPulse(8'hC3);
      end
    join
    chk("R4 busy load ignored, frame kept", got[9:0], mkFrame(8'h3C, 8, 0, 0) & 12'h3FF);
    repeat (12) @(negedge clk);
    for (int k = 0; k < 60; k++) begin
      if (txLine !== 1'b1) stayedMark = 1'b0;
      @(negedge clk);
    end
    chk("R4 no second frame", stayedMark, 1);
  endtask

  task automatic testBreak();
    int waitCnt = 0;
    setCfg(8, 1'b0, 1'b0, 1'b0);
    txBreak = 1'b1;
    @(negedge clk);
    chk("R5 break while idle", txLine, 0);
    txBreak = 1'b0;
    repeat (2) @(negedge clk);
    txPulse(8'hFF);
    repeat (30) @(negedge clk);
    txBreak = 1'b1;
    @(negedge clk);
    chk("R5 break mid frame", txLine, 0);
    repeat (20) @(negedge clk);
    chk("R5 break over mark data", txLine, 0);
    repeat (20) @(negedge clk);
    chk("R5 break held", txLine, 0);
    txBreak = 1'b0;
    while (txReady !== 1'b1 && waitCnt < 300) begin
      @(negedge clk);
      waitCnt++;
    end
    repeat (2) @(negedge clk);
    chk("R5 line mark after release", txLine, 1);
  endtask

  task automatic testRx(input string req, input logic [7:0] d, input int nd,
                        input logic pOn, input logic odd, input logic flipPar,
                        input logic badStop, input logic haltEn);
    int len = 1 + nd + int'(pOn) + 1;
    int v0 = validCnt, s0 = startCnt, h0 = haltCnt;
    logic [11:0] f;
    setCfg(nd, pOn, odd, 1'b0);
    haltOnFrameErr = haltEn;
    f = mkFrame(d, nd, pOn, odd);
    if (flipPar) f[1+nd] = ~f[1+nd];
    if (badStop) f[len-1] = 1'b0;
    rxDrive(f, len);
    chk({req, " R9 one rxValid"}, validCnt - v0, 1);
    chk({req, " R7 one startSeen"}, startCnt - s0, 1);
    chk({req, " R8 data"}, lastData, expRx(f, nd, pOn));
    chk({req, " R9 frameErr"}, lastFe, badStop);
    chk({req, " R10 halt"}, haltCnt - h0, int'(badStop && haltEn));
    if (badStop && haltEn) chk({req, " R10 halt with valid"}, lastHalt, 1);
  endtask

  task automatic testGlitch();
    int v0 = validCnt, s0 = startCnt;
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (80) @(negedge clk);
    chk("R6 glitch no start", startCnt - s0, 0);
    chk("R6 glitch no char", validCnt - v0, 0);
  endtask

  task automatic testDuplex();
    logic [11:0] got, f;
    int v0 = validCnt;
    setCfg(7, 1'b1, 1'b1, 1'b0);
    haltOnFrameErr = 1'b0;
    f = mkFrame(8'h5A, 7, 1, 1);
    @(negedge clk);
    txData = 8'h2D;
    txLoad = 1'b1;
    rxLine = 1'b0;
    @(negedge clk);
    txLoad = 1'b0;
    fork
      txCapture(10, got);
      begin
        repeat (15) @(negedge clk);
        for (int k = 1; k < 10; k++) begin
          rxLine = f[k];
          repeat (16) @(negedge clk);
        end
        rxLine = 1'b1;
      end
    join
    repeat (20) @(negedge clk);
    chk("R2 R3 duplex tx frame", got[9:0], mkFrame(8'h2D, 7, 1, 1) & 12'h3FF);
    chk("R8 duplex rx count", validCnt - v0, 1);
    chk("R8 duplex rx data", lastData, expRx(f, 7, 1));
    chk("R9 duplex rx stop ok", lastFe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testTx("R1 R2 8N1", 8'hA5, 8, 0, 0, 0);
    testTx("R1 R3 7E2", 8'h35, 7, 1, 0, 1);
    testTx("R1 R3 6O1", 8'h2B, 6, 1, 1, 0);
    testTx("R1 R3 5O2", 8'h16, 5, 1, 1, 1);
    testTx("R1 R2 5N1", 8'hF3, 5, 0, 0, 0);
    testTx("R3 8E1", 8'h81, 8, 1, 0, 0);
    testLoadBusy();
    testBreak();
    testRx("R8 8-bit parity", 8'hC6, 8, 1, 0, 0, 0, 0);
    testRx("R8 7-bit even flipped", 8'h4D, 7, 1, 0, 1, 0, 0);
    testRx("R8 5-bit odd", 8'h1B, 5, 1, 1, 0, 0, 0);
    testRx("R1 6-bit no parity", 8'h2A, 6, 0, 0, 0, 0, 0);
    testRx("R9 R10 bad stop halt on", 8'h55, 8, 0, 0, 0, 1, 1);
    testRx("R10 bad stop halt off", 8'h0F, 8, 0, 0, 0, 1, 0);
    testRx("R9 good stop clears", 8'h71, 8, 0, 0, 0, 0, 1);
    testGlitch();
    testDuplex();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule